// File: doc/BRIEF.md
# Two-Wire Command and Address Register Port

This block is a slave on a two-wire serial bus (I2C signalling, 7-bit addressing) that gives a host access to a controller's command and address registers. The host writes either one command byte or a command byte followed by the high and the low half of a 16-bit address. It reads back a status byte, then the high half of the core's current address, then its low half. In the low half, the five least significant bits are always returned as zero. Both bus lines are brought into the system clock domain through flop synchronizers. The system clock must run at least eight times faster than the bus clock.

Bytes that arrive during a write are first held in staging registers. The core registers change only when a STOP closes a frame. A one-byte frame updates the command and pulses a command strobe. A frame of three or more bytes also updates the address and pulses an address strobe in the same cycle. Toward the core the block has a parallel interface. The core supplies the status byte and the current address, and the block returns the loaded values together with their strobes.

Top module: `i2c_cmd_port`

## Requirements
- R1: The slave acknowledges only the 7-bit address 0x40, that is the byte 80h for a write and 81h for a read. For any other address it gives no acknowledge, acknowledges no following byte, raises no strobe and leaves SDA released until the next START.
- R2: A write frame with exactly one data byte loads that byte into cmd_o and pulses cmd_strobe high for one cycle after the STOP. addr_o is left unchanged and addr_strobe stays low.
- R3: A write frame with three data bytes (command, address high, address low) sets cmd_o to the first byte and addr_o to {second, third}. cmd_strobe and addr_strobe pulse together in the same cycle.
- R4: A write frame that stops after two data bytes updates only the command. The partial address is discarded, addr_o keeps its value and addr_strobe stays low.
- R5: Data bytes after the third in a write frame are acknowledged and have no effect. The first three bytes are committed as in R3.
- R6: cmd_o, addr_o and the strobes change only after a STOP. A repeated START throws away the bytes staged so far and counts the new frame's bytes from zero.
- R7: A read returns status_i first, then rd_addr_i[15:8], then {rd_addr_i[7:5], 5'b00000}. Any further byte reads as FFh, with SDA released.
- R8: When the host answers a read byte with a NACK, the slave releases SDA and waits for STOP. A STOP right after the status byte leaves the slave idle and ready for the next frame.
- R9: The slave drives SDA low during the ninth clock of every byte it acknowledges. It changes SDA only while SCL is low.
- R10: After a synchronous active-high reset, sda_oe, cmd_o, addr_o, cmd_strobe and addr_strobe are all zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 8x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low (open drain) |
| status_i | input | 8 | Status byte returned first on a read |
| rd_addr_i | input | 16 | Core's current address, returned on a read |
| cmd_o | output | 8 | Last committed command byte |
| addr_o | output | 16 | Last committed address |
| cmd_strobe | output | 1 | One-cycle pulse when cmd_o is loaded |
| addr_strobe | output | 1 | One-cycle pulse when addr_o is loaded |

## Verification
Some rules are checked by assertions on every cycle. SDA may change only while the synchronized SCL is low. SDA stays released while the slave ignores a foreign address. An address strobe never appears without a command strobe. A strobe follows only a STOP and lasts one cycle. Other behaviour only the bench scenarios can show: which frame lengths commit which registers, that a repeated START discards staged bytes, that the masked low address byte and the FFh filler are read back correctly, and that the slave recovers after an early STOP in a read.

// File: rtl/i2c_cmd_pkg.sv
package i2c_cmd_pkg;

    typedef enum logic [3:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_WDATA,
        ST_WACK,
        ST_RDATA,
        ST_RACK,
        ST_RNEXT,
        ST_SKIP
    } bus_st_e;

    // Bus events derived from the synchronized lines.
    typedef struct packed {
        logic start;
        logic stop;
        logic scl_rise;
        logic scl_fall;
        logic scl;
        logic sda;
    } bus_ev_t;

    // One received write data byte with its position in the frame (saturating).
    typedef struct packed {
        logic       valid;
        logic [1:0] idx;
        logic [7:0] data;
    } wbyte_t;

    // Byte returned at read position idx; positions past the third read as FFh.
    function automatic logic [7:0] rd_byte(input logic [1:0] idx,
                                           input logic [7:0] status,
                                           input logic [15:0] addr,
                                           input int unsigned zero_bits);
        logic [7:0] mask;
        mask = 8'hFF << zero_bits;
        case (idx)
            2'd0:    return status;
            2'd1:    return addr[15:8];
            2'd2:    return addr[7:0] & mask;
            default: return 8'hFF;
        endcase
    endfunction

endpackage

// File: rtl/i2c_line_sync.sv
module i2c_line_sync
    import i2c_cmd_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    scl_i,
    input  logic    sda_i,
    output bus_ev_t ev
);
    localparam int NLINES = 2;

    logic [NLINES-1:0] raw;
    logic [NLINES-1:0] synced;
    logic [NLINES-1:0] prev;

    assign raw = {scl_i, sda_i};

    // One synchronizer chain per bus line; idle level is high.
    for (genvar g = 0; g < NLINES; g++) begin : g_line
        logic [STAGES-1:0] chain;
        always_ff @(posedge clk) begin
            if (rst) chain <= '1;
            else     chain <= {chain[STAGES-2:0], raw[g]};
        end
        assign synced[g] = chain[STAGES-1];
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= '1;
        else     prev <= synced;
    end

    logic scl_s, sda_s, scl_p, sda_p;
    assign scl_s = synced[1];
    assign sda_s = synced[0];
    assign scl_p = prev[1];
    assign sda_p = prev[0];

    always_comb begin
        ev.scl      = scl_s;
        ev.sda      = sda_s;
        ev.scl_rise = scl_s & ~scl_p;
        ev.scl_fall = ~scl_s & scl_p;
        ev.start    = scl_s & scl_p & sda_p & ~sda_s;
        ev.stop     = scl_s & scl_p & ~sda_p & sda_s;
    end
endmodule

// File: rtl/i2c_frame_fsm.sv
module i2c_frame_fsm
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR  = 7'h40,
    parameter int unsigned ZERO_BITS = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  bus_ev_t     ev,
    input  logic [7:0]  status_i,
    input  logic [15:0] rd_addr_i,
    output logic        sda_oe,
    output wbyte_t      wb
);
    bus_st_e    st;
    logic [2:0] bit_cnt;
    logic [7:0] sh;
    logic       full;
    logic       rw;
    logic [1:0] wr_idx;
    logic [1:0] rd_idx;
    logic       oe_q;

    logic [1:0] nxt_idx;
    logic [1:0] sel_idx;
    logic [7:0] tx_load;

    always_comb begin
        nxt_idx = (rd_idx == 2'd3) ? 2'd3 : rd_idx + 2'd1;
        sel_idx = (st == ST_ADDR_ACK) ? 2'd0 : nxt_idx;
        tx_load = rd_byte(sel_idx, status_i, rd_addr_i, ZERO_BITS);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            sh      <= '0;
            full    <= 1'b0;
            rw      <= 1'b0;
            wr_idx  <= '0;
            rd_idx  <= '0;
            oe_q    <= 1'b0;
            wb      <= '0;
        end else begin
            wb.valid <= 1'b0;
            if (ev.start) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                full    <= 1'b0;
                wr_idx  <= '0;
                rd_idx  <= '0;
                oe_q    <= 1'b0;
            end else if (ev.stop) begin
                st   <= ST_IDLE;
                oe_q <= 1'b0;
            end else begin
                case (st)
                    ST_ADDR, ST_WDATA: begin
                        if (ev.scl_rise && !full) begin
                            sh      <= {sh[6:0], ev.sda};
                            bit_cnt <= bit_cnt + 3'd1;
                            if (bit_cnt == 3'd7) full <= 1'b1;
                        end else if (ev.scl_fall && full) begin
                            full <= 1'b0;
                            if (st == ST_ADDR) begin
                                if (sh[7:1] == DEV_ADDR) begin
                                    st   <= ST_ADDR_ACK;
                                    oe_q <= 1'b1;
                                    rw   <= sh[0];
                                end else begin
                                    st <= ST_SKIP;
                                end
                            end else begin
                                st      <= ST_WACK;
                                oe_q    <= 1'b1;
                                wb.valid <= 1'b1;
                                wb.idx  <= wr_idx;
                                wb.data <= sh;
                                if (wr_idx != 2'd3) wr_idx <= wr_idx + 2'd1;
                            end
                        end
                    end
                    ST_ADDR_ACK: begin
                        if (ev.scl_fall) begin
                            if (rw) begin
                                st      <= ST_RDATA;
                                sh      <= tx_load;
                                oe_q    <= ~tx_load[7];
                                bit_cnt <= '0;
                            end else begin
                                st   <= ST_WDATA;
                                oe_q <= 1'b0;
                            end
                        end
                    end
                    ST_WACK: begin
                        if (ev.scl_fall) begin
                            st   <= ST_WDATA;
                            oe_q <= 1'b0;
                        end
                    end
                    ST_RDATA: begin
                        if (ev.scl_fall) begin
                            if (bit_cnt == 3'd7) begin
                                st   <= ST_RACK;
                                oe_q <= 1'b0;
                            end else begin
                                sh      <= {sh[6:0], 1'b0};
                                oe_q    <= ~sh[6];
                                bit_cnt <= bit_cnt + 3'd1;
                            end
                        end
                    end
                    ST_RACK: begin
                        if (ev.scl_rise) st <= ev.sda ? ST_SKIP : ST_RNEXT;
                    end
                    ST_RNEXT: begin
                        if (ev.scl_fall) begin
                            st      <= ST_RDATA;
                            rd_idx  <= nxt_idx;
                            sh      <= tx_load;
                            oe_q    <= ~tx_load[7];
                            bit_cnt <= '0;
                        end
                    end
                    ST_IDLE, ST_SKIP: ;
                    default: st <= ST_IDLE;
                endcase
            end
        end
    end

    assign sda_oe = oe_q;

    // R9: the data line is only changed while the clock is low.
    p_sda_scl_low_r9: assert property (@(posedge clk) disable iff (rst)
        !$stable(oe_q) && !$past(ev.start || ev.stop) |-> !ev.scl);

    // R1: an ignored frame never pulls the data line.
    p_skip_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (st == ST_SKIP) |-> !oe_q);

    // R8: after a NACK from the host the slave leaves the line released.
    p_nack_release_r8: assert property (@(posedge clk) disable iff (rst)
        (st == ST_RACK) && ev.scl_rise && ev.sda |=> !oe_q);
endmodule

// File: rtl/i2c_reg_commit.sv
module i2c_reg_commit
    import i2c_cmd_pkg::*;
#(
    parameter int CMD_W  = 8,
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              frame_start,
    input  logic              frame_stop,
    input  wbyte_t            wb,
    output logic [CMD_W-1:0]  cmd_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic              cmd_strobe,
    output logic              addr_strobe
);
    localparam int HALF_W = ADDR_W / 2;

    logic [CMD_W-1:0]  stage_cmd;
    logic [HALF_W-1:0] stage_hi;
    logic [HALF_W-1:0] stage_lo;
    logic [1:0]        got;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage_cmd   <= '0;
            stage_hi    <= '0;
            stage_lo    <= '0;
            got         <= '0;
            cmd_o       <= '0;
            addr_o      <= '0;
            cmd_strobe  <= 1'b0;
            addr_strobe <= 1'b0;
        end else begin
            cmd_strobe  <= 1'b0;
            addr_strobe <= 1'b0;
            if (frame_start) begin
                got <= '0;
            end else if (frame_stop) begin
                got <= '0;
                if (got != 2'd0) begin
                    cmd_o      <= stage_cmd;
                    cmd_strobe <= 1'b1;
                end
                if (got == 2'd3) begin
                    addr_o      <= {stage_hi, stage_lo};
                    addr_strobe <= 1'b1;
                end
            end else if (wb.valid) begin
                case (wb.idx)
                    2'd0:    stage_cmd <= wb.data[CMD_W-1:0];
                    2'd1:    stage_hi  <= wb.data[HALF_W-1:0];
                    2'd2:    stage_lo  <= wb.data[HALF_W-1:0];
                    default: ;
                endcase
                if (got != 2'd3) got <= got + 2'd1;
            end
        end
    end

    // R3: an address is never committed without its command.
    p_addr_with_cmd_r3: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |-> cmd_strobe);

    // R6: commits follow a STOP only.
    p_commit_after_stop_r6: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |-> $past(frame_stop));

    // R2: the strobe is a single-cycle pulse.
    p_strobe_pulse_r2: assert property (@(posedge clk) disable iff (rst)
        cmd_strobe |=> !cmd_strobe);
endmodule

// File: rtl/i2c_cmd_port.sv
module i2c_cmd_port
    import i2c_cmd_pkg::*;
#(
    parameter logic [6:0]  DEV_ADDR    = 7'h40,
    parameter int          SYNC_STAGES = 2,
    parameter int unsigned ZERO_BITS   = 5
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        scl_i,
    input  logic        sda_i,
    output logic        sda_oe,
    input  logic [7:0]  status_i,
    input  logic [15:0] rd_addr_i,
    output logic [7:0]  cmd_o,
    output logic [15:0] addr_o,
    output logic        cmd_strobe,
    output logic        addr_strobe
);
    bus_ev_t ev;
    wbyte_t  wb;

    i2c_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst   (rst),
        .scl_i (scl_i),
        .sda_i (sda_i),
        .ev    (ev)
    );

    i2c_frame_fsm #(.DEV_ADDR(DEV_ADDR), .ZERO_BITS(ZERO_BITS)) u_fsm (
        .clk       (clk),
        .rst       (rst),
        .ev        (ev),
        .status_i  (status_i),
        .rd_addr_i (rd_addr_i),
        .sda_oe    (sda_oe),
        .wb        (wb)
    );

    i2c_reg_commit #(.CMD_W(8), .ADDR_W(16)) u_commit (
        .clk         (clk),
        .rst         (rst),
        .frame_start (ev.start),
        .frame_stop  (ev.stop),
        .wb          (wb),
        .cmd_o       (cmd_o),
        .addr_o      (addr_o),
        .cmd_strobe  (cmd_strobe),
        .addr_strobe (addr_strobe)
    );
endmodule

// File: tb/i2c_cmd_port_tb.sv
module i2c_cmd_port_tb;
    localparam int Q = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        scl_drv = 1'b1;
    logic        host_low = 1'b0;
    logic        sda_line;
    logic        sda_oe;
    logic [7:0]  status_i = 8'h00;
    logic [15:0] rd_addr_i = 16'h0000;
    logic [7:0]  cmd_o;
    logic [15:0] addr_o;
    logic        cmd_strobe, addr_strobe;

    int total = 0, bad = 0;
    int n_cmd = 0, n_addr = 0, pair_err = 0;
    logic [7:0]  exp_cmd = 8'h00;
    logic [15:0] exp_addr = 16'h0000;

    always #5 clk = ~clk;
    assign sda_line = ~(host_low | sda_oe);

    i2c_cmd_port u_dut (
        .clk(clk), .rst(rst), .scl_i(scl_drv), .sda_i(sda_line), .sda_oe(sda_oe),
        .status_i(status_i), .rd_addr_i(rd_addr_i), .cmd_o(cmd_o), .addr_o(addr_o),
        .cmd_strobe(cmd_strobe), .addr_strobe(addr_strobe)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (cmd_strobe) n_cmd++;
            if (addr_strobe) n_addr++;
            if (addr_strobe && !cmd_strobe) pair_err++;
        end
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic wq(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic h_start;
        host_low = 1'b0; scl_drv = 1'b1; wq(Q);
        host_low = 1'b1; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic h_stop;
        host_low = 1'b1; wq(Q);
        scl_drv = 1'b1; wq(Q);
        host_low = 1'b0; wq(2 * Q);
    endtask

    task automatic bit_w(input logic b);
        host_low = ~b; wq(Q);
        scl_drv = 1'b1; wq(2 * Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic bit_r(output logic b);
        host_low = 1'b0; wq(Q);
        scl_drv = 1'b1; wq(Q);
        b = sda_line; wq(Q);
        scl_drv = 1'b0; wq(Q);
    endtask

    task automatic wr_byte(input logic [7:0] d, output logic acked);
        logic b;
        for (int i = 7; i >= 0; i--) bit_w(d[i]);
        bit_r(b);
        acked = ~b;
    endtask

    task automatic rd_byte_h(input logic nack, output logic [7:0] d);
        logic b;
        for (int i = 7; i >= 0; i--) begin
            bit_r(b);
            d[i] = b;
        end
        bit_w(nack);
    endtask

    function automatic logic [7:0] exp_rd(input int k, input logic [7:0] s, input logic [15:0] a);
        if (k == 0) return s;
        if (k == 1) return a[15:8];
        if (k == 2) return {a[7:5], 5'b00000};
        return 8'hFF;
    endfunction

    // Full write frame of n data bytes; checks every acknowledge and the commit.
    task automatic do_write(input int n, input logic [7:0] b0, input logic [7:0] b1,
                            input logic [7:0] b2, input logic [7:0] b3);
        logic ack;
        int c0, a0;
        logic [7:0] bytes [4];
        bytes[0] = b0; bytes[1] = b1; bytes[2] = b2; bytes[3] = b3;
        c0 = n_cmd; a0 = n_addr;
        h_start;
        wr_byte(8'h80, ack);
        chk(ack, "R1 write address ack", ack, 1);
        for (int i = 0; i < n; i++) begin
            wr_byte(bytes[i % 4], ack);
            chk(ack, (i >= 3) ? "R5 extra byte ack" : "R9 data ack", ack, 1);
        end
        chk(n_cmd == c0, "R6 no commit before stop", n_cmd - c0, 0);
        h_stop;
        wq(4);
        if (n >= 1) exp_cmd = b0;
        if (n >= 3) exp_addr = {b1, b2};
        chk(n_cmd - c0 == ((n >= 1) ? 1 : 0), (n == 1) ? "R2 cmd strobe count" : "R3 cmd strobe count",
            n_cmd - c0, (n >= 1) ? 1 : 0);
        chk(n_addr - a0 == ((n >= 3) ? 1 : 0), (n == 2) ? "R4 no addr strobe" : "R3 addr strobe count",
            n_addr - a0, (n >= 3) ? 1 : 0);
        chk(cmd_o == exp_cmd, "R2 cmd value", cmd_o, exp_cmd);
        chk(addr_o == exp_addr, (n >= 4) ? "R5 addr value" : "R4 addr value", addr_o, exp_addr);
        chk(sda_oe == 1'b0, "R8 released after stop", sda_oe, 0);
    endtask

    task automatic do_read(input int n, input logic [7:0] s, input logic [15:0] a);
        logic ack;
        logic [7:0] d;
        int c0;
        c0 = n_cmd;
        status_i = s; rd_addr_i = a;
        h_start;
        wr_byte(8'h81, ack);
        chk(ack, "R1 read address ack", ack, 1);
        for (int k = 0; k < n; k++) begin
            rd_byte_h(k == n - 1, d);
            chk(d == exp_rd(k, s, a), "R7 read byte", d, exp_rd(k, s, a));
        end
        chk(sda_oe == 1'b0, "R8 released after nack", sda_oe, 0);
        h_stop;
        wq(4);
        chk(n_cmd == c0, "R7 read commits nothing", n_cmd - c0, 0);
    endtask

    initial begin
        logic ack;
        int kind;
        wq(5);
        chk(sda_oe == 0 && cmd_o == 0 && addr_o == 0 && !cmd_strobe && !addr_strobe,
            "R10 reset state", {sda_oe, cmd_o, addr_o[6:0]}, 0);
        rst = 1'b0;
        wq(10);

        do_write(1, 8'hA5, 8'h00, 8'h00, 8'h00);
        do_write(3, 8'h3C, 8'h12, 8'h34, 8'h00);
        do_write(2, 8'h77, 8'h99, 8'h00, 8'h00);
        do_write(5, 8'h5A, 8'hBE, 8'hEF, 8'h11);

        // R1: foreign address is ignored.
        begin
            int c0;
            c0 = n_cmd;
            h_start;
            wr_byte(8'h82, ack);
            chk(!ack, "R1 foreign address nack", ack, 0);
            wr_byte(8'h00, ack);
            chk(!ack, "R1 no data ack after foreign", ack, 0);
            h_stop;
            wq(4);
            chk(n_cmd == c0 && cmd_o == exp_cmd, "R1 no commit", n_cmd - c0, 0);
        end

        // R6: repeated START discards staged bytes.
        begin
            int c0, a0;
            c0 = n_cmd; a0 = n_addr;
            h_start;
            wr_byte(8'h80, ack);
            wr_byte(8'hC1, ack); wr_byte(8'hC2, ack); wr_byte(8'hC3, ack);
            host_low = 1'b0; wq(Q); scl_drv = 1'b1; wq(Q);
            chk(n_cmd == c0, "R6 nothing before repeated start", n_cmd - c0, 0);
            h_start;
            wr_byte(8'h80, ack);
            wr_byte(8'hD4, ack);
            h_stop;
            wq(4);
            exp_cmd = 8'hD4;
            chk(n_cmd - c0 == 1 && n_addr == a0, "R6 one cmd only", n_addr - a0, 0);
            chk(cmd_o == 8'hD4, "R6 cmd from new frame", cmd_o, 8'hD4);
            chk(addr_o == exp_addr, "R6 addr kept", addr_o, exp_addr);
        end

        do_read(4, 8'h81, 16'hA5FF);
        do_read(1, 8'h3E, 16'h1234);
        do_write(1, 8'h42, 8'h00, 8'h00, 8'h00);

        void'($urandom(32'd2024));
        for (int t = 0; t < 24; t++) begin
            kind = $urandom % 5;
            if (kind == 4) do_read(1 + ($urandom % 4), 8'($urandom), 16'($urandom));
            else do_write(kind + 1 + ((kind == 3) ? ($urandom % 2) : 0),
                          8'($urandom), 8'($urandom), 8'($urandom), 8'($urandom));
        end

        chk(pair_err == 0, "R3 addr strobe paired", pair_err, 0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule